// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a fast system clock into the bit-level timing a CAN receiver needs. A programmable prescaler divides the clock into time quanta. Every bit starts with a one-quantum synchronization slot. A first timing span follows, which holds both the propagation allowance and the first phase buffer. A second span, the second phase buffer, closes the bit. The receive line is latched at the point where the first span hands over to the second.

The unit follows the bus in two ways. While the frame layer reports the bus as idle, a falling edge on the receive line (recessive to dominant) restarts the bit at once. Inside a frame, a falling edge outside the sync slot moves the bit boundary, but never by more than the programmed jump width. A mode input chooses how the segment fields are read: either as the exact number of quanta, or as one less than that number. The resulting sample-point position is reported in quanta, so that the configurations of different nodes can be compared directly.

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts `cfg_brp + 1` clock cycles. With no edges on `rx_in`, bits follow one another back to back, each `(1 + T1 + T2) * (cfg_brp + 1)` clocks long, measured from one `bit_stb` pulse to the next.
- R2: The effective spans are T1 = `cfg_tseg1` and T2 = `cfg_tseg2` when `cfg_plus1` is 0. The synchronization slot is always exactly one quantum.
- R3: On a clean bit, `sample_stb` pulses `(1 + T1) * (cfg_brp + 1)` clocks after the bit's `bit_stb`. In that same cycle `rx_bit` takes the value the receive line held at the sample point. For example, T1=13 and T2=2 put the sample at quantum 14 of 16, which is 87.5 %.
- R4: When `cfg_plus1` is 1, T1 = `cfg_tseg1 + 1` and T2 = `cfg_tseg2 + 1`, and the sample point and bit length move to match. `cfg_sjw` is always used as programmed.
- R5: `sp_quanta` equals 1 + T1 for the current configuration.
- R6: With `bus_idle` high, a 1-to-0 change on `rx_in` is a hard sync. `bit_stb` pulses two clocks after `rx_in` is first sampled low, and the new bit starts from its sync slot. SJW does not limit a hard sync.
- R7: With `bus_idle` low, a falling edge seen in quantum q of the first span (1 ≤ q ≤ T1) lengthens that span by min(q, `cfg_sjw`) quanta. Rising edges cause no adjustment.
- R8: A falling edge seen in the second span, with phase error e = (quanta left until the nominal bit end), ends the bit at once (`bit_stb` next clock) when e ≤ `cfg_sjw`. Otherwise it shortens the second span by `cfg_sjw` quanta.
- R9: At most one resynchronization is applied per bit, and none is applied after a hard sync in that bit. A falling edge seen during the sync slot causes no adjustment.
- R10: `sample_stb` and `bit_stb` are single-clock pulses and never high together. In reset both are low and `rx_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_brp | input | BRP_W | Prescaler value; one quantum lasts cfg_brp+1 clocks |
| cfg_tseg1 | input | SEG_W | First span (propagation plus phase 1) field |
| cfg_tseg2 | input | SEG_W | Second span (phase 2) field |
| cfg_sjw | input | SJW_W | Resynchronization jump width in quanta |
| cfg_plus1 | input | 1 | 1: add one quantum to each span field internally |
| bus_idle | input | 1 | From the frame layer: bus idle, next falling edge is a hard sync |
| rx_in | input | 1 | Raw receive line, 1 = recessive |
| rx_bit | output | 1 | Bit value latched at the sample point |
| sample_stb | output | 1 | One-clock pulse when rx_bit is updated |
| bit_stb | output | 1 | One-clock pulse at the start of each bit |
| sp_quanta | output | SEG_W+3 | Effective sample-point position in quanta from bit start |

## Verification
The bench uses the default widths: an 8-bit prescaler, 5-bit span fields and a 3-bit jump width. These reach a 13/2 split at two clocks per quantum, a plus-one split with a single-clock quantum, and a 3/3 split where the jump width equals the whole second span. The last case lets an early edge end a bit before it would normally end, and it makes long random edge sequences exercise every resynchronization branch. Targeted edges are placed at exact quantum offsets to check the lengthen, shorten, sync-slot and second-edge rules against hand-computed bit lengths.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    localparam int CBT_BRP_W = 8;
    localparam int CBT_SEG_W = 5;
    localparam int CBT_SJW_W = 3;

    // Classification of a detected falling edge
    typedef enum logic [1:0] {
        EDGE_NONE,
        EDGE_HARD,
        EDGE_LATE,
        EDGE_EARLY
    } edge_kind_e;

    // Span length after the interpretation mode has been applied
    function automatic int unsigned span_eff(input int unsigned raw, input logic plus1);
        return raw + {31'd0, plus1};
    endfunction

endpackage

// File: rtl/can_bt_edge.sv
module can_bt_edge (
    input  logic clk,
    input  logic rst,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);
    logic rx_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_s <= 1'b1;
            rx_p <= 1'b1;
        end else begin
            rx_s <= rx_in;
            rx_p <= rx_s;
        end
    end

    assign fall = rx_p & ~rx_s;
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
    parameter int BRP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BRP_W-1:0] brp,
    input  logic             restart,
    output logic             tick
);
    logic [BRP_W-1:0] cnt;

    assign tick = (cnt == brp);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int Q_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [Q_W-1:0] t1,
    input  logic [Q_W-1:0] t2,
    input  logic [Q_W-1:0] sjw,
    input  logic           tick,
    input  logic           fall,
    input  logic           rx_s,
    input  logic           bus_idle,
    output logic           restart,
    output logic           rx_bit,
    output logic           sample_stb,
    output logic           bit_stb
);
    typedef struct packed {
        logic [Q_W-1:0] l1;   // last quantum index of the first span
        logic [Q_W-1:0] l2;   // last quantum index of the bit
    } lim_t;

    logic [Q_W-1:0] q;
    logic           done;
    lim_t           lim, lim_nx, nom;
    edge_kind_e     kind;
    logic [Q_W-1:0] late_adj, early_err;

    always_comb begin
        nom.l1 = t1;
        nom.l2 = t1 + t2;
    end

    always_comb begin
        kind = EDGE_NONE;
        if (fall) begin
            if (bus_idle)                kind = EDGE_HARD;
            else if (!done && q != '0)   kind = (q <= lim.l1) ? EDGE_LATE : EDGE_EARLY;
        end
        late_adj  = (q < sjw) ? q : sjw;
        early_err = lim.l2 + Q_W'(1) - q;
        restart   = (kind == EDGE_HARD) || ((kind == EDGE_EARLY) && (early_err <= sjw));
        lim_nx    = lim;
        if (kind == EDGE_LATE) begin
            lim_nx.l1 = lim.l1 + late_adj;
            lim_nx.l2 = lim.l2 + late_adj;
        end else if (kind == EDGE_EARLY) begin
            lim_nx.l2 = lim.l2 - sjw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q          <= '0;
            lim        <= nom;
            done       <= 1'b0;
            rx_bit     <= 1'b1;
            sample_stb <= 1'b0;
            bit_stb    <= 1'b0;
        end else begin
            sample_stb <= 1'b0;
            bit_stb    <= 1'b0;
            if (restart) begin
                q       <= '0;
                lim     <= nom;
                done    <= (kind == EDGE_HARD);
                bit_stb <= 1'b1;
            end else begin
                lim <= lim_nx;
                if (kind == EDGE_LATE || kind == EDGE_EARLY) done <= 1'b1;
                if (tick) begin
                    if (q == lim_nx.l2) begin
                        q       <= '0;
                        lim     <= nom;
                        done    <= 1'b0;
                        bit_stb <= 1'b1;
                    end else begin
                        q <= q + 1'b1;
                        if (q == lim_nx.l1) begin
                            sample_stb <= 1'b1;
                            rx_bit     <= rx_s;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
    import can_bt_pkg::*;
#(
    parameter  int BRP_W = CBT_BRP_W,
    parameter  int SEG_W = CBT_SEG_W,
    parameter  int SJW_W = CBT_SJW_W,
    localparam int Q_W   = SEG_W + 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BRP_W-1:0] cfg_brp,
    input  logic [SEG_W-1:0] cfg_tseg1,
    input  logic [SEG_W-1:0] cfg_tseg2,
    input  logic [SJW_W-1:0] cfg_sjw,
    input  logic             cfg_plus1,
    input  logic             bus_idle,
    input  logic             rx_in,
    output logic             rx_bit,
    output logic             sample_stb,
    output logic             bit_stb,
    output logic [Q_W-1:0]   sp_quanta
);
    logic [Q_W-1:0] t1, t2, sjw_q;
    logic           rx_s, fall, tick, restart;

    assign t1        = Q_W'(span_eff(32'(cfg_tseg1), cfg_plus1));
    assign t2        = Q_W'(span_eff(32'(cfg_tseg2), cfg_plus1));
    assign sjw_q     = Q_W'(cfg_sjw);
    assign sp_quanta = t1 + Q_W'(1);

    can_bt_edge edge_i (
        .clk  (clk),
        .rst  (rst),
        .rx_in(rx_in),
        .rx_s (rx_s),
        .fall (fall)
    );

    can_bt_prescaler #(.BRP_W(BRP_W)) pre_i (
        .clk    (clk),
        .rst    (rst),
        .brp    (cfg_brp),
        .restart(restart),
        .tick   (tick)
    );

    can_bt_seq #(.Q_W(Q_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .t1        (t1),
        .t2        (t2),
        .sjw       (sjw_q),
        .tick      (tick),
        .fall      (fall),
        .rx_s      (rx_s),
        .bus_idle  (bus_idle),
        .restart   (restart),
        .rx_bit    (rx_bit),
        .sample_stb(sample_stb),
        .bit_stb   (bit_stb)
    );
endmodule

// File: rtl/can_bt_chk.sv
module can_bt_chk #(
    parameter  int BRP_W = 8,
    parameter  int SEG_W = 5,
    parameter  int SJW_W = 3,
    localparam int Q_W   = SEG_W + 3
) (
    input logic             clk,
    input logic             rst,
    input logic [BRP_W-1:0] cfg_brp,
    input logic [SEG_W-1:0] cfg_tseg2,
    input logic [SJW_W-1:0] cfg_sjw,
    input logic             cfg_plus1,
    input logic             bus_idle,
    input logic             rx_in,
    input logic             sample_stb,
    input logic             bit_stb,
    input logic [Q_W-1:0]   sp_quanta
);
    localparam int SAT = 1000000;

    int   cnt, quiet, idle_q, cyc;
    logic started, rx_prev;
    int   qclk, len, sj;

    always_comb begin
        qclk = int'(cfg_brp) + 1;
        len  = int'(sp_quanta) + int'(cfg_tseg2) + int'(cfg_plus1);
        sj   = int'(cfg_sjw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= 0;
            quiet   <= 0;
            idle_q  <= 0;
            cyc     <= 0;
            started <= 1'b0;
            rx_prev <= 1'b1;
        end else begin
            cyc     <= (cyc < SAT) ? cyc + 1 : cyc;
            cnt     <= bit_stb ? 1 : ((cnt < SAT) ? cnt + 1 : cnt);
            started <= started | bit_stb;
            rx_prev <= rx_in;
            quiet   <= (rx_in != rx_prev) ? 0 : ((quiet < SAT) ? quiet + 1 : quiet);
            idle_q  <= bus_idle ? 0 : ((idle_q < SAT) ? idle_q + 1 : idle_q);
        end
    end

    AST_SAMPLE_POS: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && started && quiet > cnt + 4 && idle_q > cnt + 4) |-> (cnt == int'(sp_quanta) * qclk)); // R3

    AST_BIT_LEN: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && started && quiet > cnt + 4 && idle_q > cnt + 4) |-> (cnt == len * qclk)); // R1

    AST_RESYNC_BOUND: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && started && idle_q > cnt + 4) |-> (cnt >= (len - sj) * qclk && cnt <= (len + sj) * qclk)); // R7

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && bit_stb)); // R10

    AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb); // R10

    AST_HARD_SYNC: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 4 && $past(rx_in, 3) && !$past(rx_in, 2) && $past(bus_idle, 1)) |-> bit_stb); // R6
endmodule

bind can_bit_timing can_bt_chk #(.BRP_W(BRP_W), .SEG_W(SEG_W), .SJW_W(SJW_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_brp   (cfg_brp),
    .cfg_tseg2 (cfg_tseg2),
    .cfg_sjw   (cfg_sjw),
    .cfg_plus1 (cfg_plus1),
    .bus_idle  (bus_idle),
    .rx_in     (rx_in),
    .sample_stb(sample_stb),
    .bit_stb   (bit_stb),
    .sp_quanta (sp_quanta)
);

// File: tb/can_bit_timing_tb.sv
module can_bit_timing_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] brp = 8'd1;
    logic [4:0] tseg1 = 5'd13, tseg2 = 5'd2;
    logic [2:0] sjw = 3'd2;
    logic       plus1 = 1'b0;
    logic       bus_idle = 1'b0;
    logic       rx_in = 1'b1;
    logic       rx_bit, sample_stb, bit_stb;
    logic [7:0] spq;

    int    checks = 0, fails = 0, cyc = 0;
    string cur_req = "R10";

    always #2 clk = ~clk;

    can_bit_timing dut_i (
        .clk(clk), .rst(rst), .cfg_brp(brp), .cfg_tseg1(tseg1), .cfg_tseg2(tseg2),
        .cfg_sjw(sjw), .cfg_plus1(plus1), .bus_idle(bus_idle), .rx_in(rx_in),
        .rx_bit(rx_bit), .sample_stb(sample_stb), .bit_stb(bit_stb), .sp_quanta(spq)
    );

    // ---------------- behavioural reference model ----------------
    int m_p, m_q, m_l1, m_l2, m_rs, m_rp, T1, T2, SJ, B;
    bit m_done, e_s, e_b, e_rb;

    always @(posedge clk) begin
        int  nrs, a, e;
        bit  fall, tick, restarted;
        T1 = int'(tseg1) + int'(plus1);
        T2 = int'(tseg2) + int'(plus1);
        SJ = int'(sjw);
        B  = int'(brp);
        if (rst) begin
            m_p = 0; m_q = 0; m_l1 = T1; m_l2 = T1 + T2; m_done = 0;
            m_rs = 1; m_rp = 1; e_s = 0; e_b = 0; e_rb = 1;
        end else begin
            fall = (m_rp == 1 && m_rs == 0);
            tick = (m_p == B);
            nrs  = int'(rx_in);
            e_s = 0; e_b = 0; restarted = 0;
            if (fall && bus_idle) begin
                m_q = 0; m_p = 0; m_l1 = T1; m_l2 = T1 + T2; m_done = 1; e_b = 1; restarted = 1;
            end else if (fall && !m_done && m_q != 0) begin
                if (m_q <= m_l1) begin
                    a = (m_q < SJ) ? m_q : SJ;
                    m_l1 += a; m_l2 += a; m_done = 1;
                end else begin
                    e = m_l2 + 1 - m_q;
                    if (e <= SJ) begin
                        m_q = 0; m_p = 0; m_l1 = T1; m_l2 = T1 + T2; m_done = 0; e_b = 1; restarted = 1;
                    end else begin
                        m_l2 -= SJ; m_done = 1;
                    end
                end
            end
            if (!restarted) begin
                if (tick) begin
                    if (m_q == m_l2) begin
                        m_q = 0; m_l1 = T1; m_l2 = T1 + T2; m_done = 0; e_b = 1;
                    end else begin
                        if (m_q == m_l1) begin e_s = 1; e_rb = (m_rs != 0); end
                        m_q++;
                    end
                end
                m_p = tick ? 0 : m_p + 1;
            end
            m_rp = m_rs;
            m_rs = nrs;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (sample_stb !== e_s || bit_stb !== e_b || rx_bit !== e_rb) begin
                fails++;
                $display("FAIL %s model compare: actual s=%b b=%b d=%b expected s=%b b=%b d=%b (t=%0t)",
                         cur_req, sample_stb, bit_stb, rx_bit, e_s, e_b, e_rb, $time);
            end
        end
    end

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_test();
        end
    end

    task automatic apply_reset(input int b, input int s1, input int s2, input int j, input bit p1);
        @(negedge clk);
        rst = 1'b1; brp = 8'(b); tseg1 = 5'(s1); tseg2 = 5'(s2); sjw = 3'(j); plus1 = p1;
        bus_idle = 1'b0; rx_in = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_bit();
        int g = 0;
        do begin @(negedge clk); g++; end while (!bit_stb && g < 2000);
    endtask

    // From a bit_stb negedge: clocks to sample_stb and to next bit_stb
    task automatic measure(output int to_s, output int to_b);
        int k = 0;
        to_s = -1;
        do begin
            @(negedge clk); k++;
            if (sample_stb && to_s < 0) to_s = k;
        end while (!bit_stb && k < 2000);
        to_b = k;
    endtask

    // Drive rx at given negedge offsets (0 = the bit_stb negedge itself)
    task automatic bit_edges(input int k1, input bit v1, input int k2, input bit v2,
                             input int k3, input bit v3, output int len);
        int k = 0;
        wait_bit();
        if (k1 == 0) rx_in = v1;
        do begin
            @(negedge clk); k++;
            if (k == k1) rx_in = v1;
            if (k == k2) rx_in = v2;
            if (k == k3) rx_in = v3;
        end while (!bit_stb && k < 2000);
        len = k;
    endtask

    initial begin
        int ts, tb, len;
        logic [15:0] lfsr;

        // Reset state
        cur_req = "R10";
        repeat (2) @(negedge clk);
        check("R10", int'(sample_stb), 0, "sample_stb in reset");
        check("R10", int'(bit_stb), 0, "bit_stb in reset");
        check("R10", int'(rx_bit), 1, "rx_bit in reset");

        // Config A: 13/2 direct, 2 clocks per quantum
        apply_reset(1, 13, 2, 2, 1'b0);
        cur_req = "R1 R2 R3";
        check("R5", int'(spq), 14, "sp_quanta 13/2 direct");
        wait_bit();
        measure(ts, tb);
        check("R3", ts, 28, "sample offset 14 of 16 quanta");
        check("R2", tb, 32, "bit length 16 quanta");

        // Hard sync while idle
        cur_req = "R6";
        repeat (9) @(negedge clk);
        bus_idle = 1'b1; rx_in = 1'b0;
        @(negedge clk);
        check("R6", int'(bit_stb), 0, "no strobe one clock after edge");
        @(negedge clk);
        check("R6", int'(bit_stb), 1, "hard sync strobe");
        measure(ts, tb);
        check("R6", ts, 28, "sample after hard sync");
        bus_idle = 1'b0;
        rx_in = 1'b1;
        wait_bit();

        // Late edge in first span: q=6 > SJW=2, lengthen by 2
        cur_req = "R7";
        bit_edges(11, 1'b0, 9999, 1'b0, 9999, 1'b0, len);
        check("R7", len, 36, "late edge lengthens by SJW");

        // Rising edge ignored, early edge in second span q=14, e=2<=SJW
        cur_req = "R8";
        bit_edges(3, 1'b1, 27, 1'b0, 9999, 1'b0, len);
        check("R7", len >= 0 ? 1 : 0, 1, "rising edge ignored");
        check("R8", len, 29, "early edge ends bit at once");

        // Two falls in one bit: only the first counts (q=2 -> +2)
        cur_req = "R9";
        rx_in = 1'b1;
        wait_bit();
        bit_edges(3, 1'b0, 7, 1'b1, 9, 1'b0, len);
        check("R9", len, 36, "second edge in bit ignored");

        // Edge in sync slot: no adjustment
        rx_in = 1'b1;
        wait_bit();
        bit_edges(0, 1'b0, 9999, 1'b0, 9999, 1'b0, len);
        check("R9", len, 32, "sync slot edge no adjustment");

        // Sample value latched
        cur_req = "R3";
        rx_in = 1'b0;
        wait_bit();
        measure(ts, tb);
        check("R3", int'(rx_bit), 0, "rx_bit dominant latched");

        // Config B: plus-one mode, 5/1 -> 6/2, one clock per quantum
        apply_reset(0, 5, 1, 1, 1'b1);
        cur_req = "R4";
        check("R4", int'(spq), 7, "sp_quanta plus-one mode");
        wait_bit();
        measure(ts, tb);
        check("R4", ts, 7, "sample offset plus-one");
        check("R4", tb, 9, "bit length plus-one");
        apply_reset(0, 5, 1, 1, 1'b0);
        check("R5", int'(spq), 6, "sp_quanta direct mode same fields");

        // Config C: 3/3, SJW 3, 4 clocks per quantum
        apply_reset(3, 3, 3, 3, 1'b0);
        cur_req = "R1";
        wait_bit();
        measure(ts, tb);
        check("R1", tb, 28, "bit length with 4-clock quanta");
        check("R1", ts, 16, "sample offset with 4-clock quanta");

        // Random edges, model compared every clock
        cur_req = "R6 R7 R8 R9";
        lfsr = 16'hACE1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:0] == 4'h0) rx_in = ~rx_in;
            bus_idle = (lfsr[15:11] == 5'h1F);
        end
        finish_test();
    end
endmodule